// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block makes the first-level address decision for a received Ethernet frame. When the receive path has collected a frame's 48-bit destination and source addresses, it pulses a valid strobe. The filter then classifies the destination as unicast, multicast or broadcast. A unicast destination is compared with the station address. Multicast and broadcast destinations go through their own policies. A hash-match input from an external multicast hash table stands in for hash filtering.

One clock after the strobe the block presents a registered verdict: a pass flag and two status flags for the receive status word, destination-fail and source-fail. These stay unchanged until the next strobe. Four level-sensitive controls select the policy: promiscuous, inverse destination matching, pass-all-multicast and broadcast-drop. All four are driven 0 from configuration after reset, which gives normal filtering.

Top module: `rxaf_top`

## Requirements
- R1: A verdict is presented with `res_valid` high exactly one clock after a cycle with `in_valid` high. `res_valid` is low in every cycle that does not follow an `in_valid` cycle.
- R2: While `rst` is high, and in the first cycle after it, `res_valid`, `res_pass`, `res_da_fail` and `res_sa_fail` are all 0.
- R3: With `cfg_promisc` = 1, every frame gets `res_pass` = 1, whatever its addresses and the other controls.
- R4: With `cfg_promisc` = 1, `res_da_fail` and `res_sa_fail` are both 0.
- R5: A unicast destination (`dst_addr[0]` = 0) passes when it equals `station_addr` bit for bit and is dropped otherwise. This holds when neither promiscuous mode nor inverse mode is set.
- R6: A destination is multicast when `dst_addr[0]` = 1 and it is not all ones. This bit is the group bit, the first bit transmitted, with byte 0 of the field in bits 7:0. With `cfg_pass_mcast` = 1, every multicast frame passes, whatever `hash_hit` and `cfg_inv_da` are.
- R7: With `cfg_pass_mcast` = 0, a multicast frame passes when `hash_hit` = 1 and is dropped when `hash_hit` = 0. This holds when inverse mode is clear.
- R8: A destination of all ones is broadcast. With `cfg_drop_bcast` = 1 it is dropped; with `cfg_drop_bcast` = 0 it passes. Neither `cfg_pass_mcast` nor `cfg_inv_da` changes this outcome.
- R9: With `cfg_inv_da` = 1, the destination match result is inverted for both kinds of frame. For unicast this is the station compare. For multicast with `cfg_pass_mcast` = 0 it is `hash_hit`.
- R10: Outside promiscuous mode, `res_da_fail` is the complement of `res_pass`. `res_sa_fail` equals `src_addr[0]`, so a group source address fails. The source check never changes `res_pass`.
- R11: Between verdicts, `res_pass`, `res_da_fail` and `res_sa_fail` keep the values of the last verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_promisc | input | 1 | Pass every frame and clear both fail flags |
| cfg_inv_da | input | 1 | Invert the destination match result |
| cfg_pass_mcast | input | 1 | Pass all multicast frames |
| cfg_drop_bcast | input | 1 | Drop broadcast frames |
| station_addr | input | 48 | Programmed station address |
| in_valid | input | 1 | Addresses and hash_hit are valid this cycle |
| dst_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| src_addr | input | 48 | Source address, byte 0 in bits 7:0 |
| hash_hit | input | 1 | External multicast hash table hit |
| res_valid | output | 1 | Verdict strobe |
| res_pass | output | 1 | Frame passes the filter |
| res_da_fail | output | 1 | Destination-fail status |
| res_sa_fail | output | 1 | Source-fail status |

## Verification
Every verdict is due in the cycle right after its `in_valid` strobe, because one register separates the inputs from the outputs. The driver changes inputs on the falling edge and pushes the expected verdict into a queue. The monitor samples a few nanoseconds after each rising edge, pops one entry for each `res_valid` it sees, and flags a strobe that arrives with nothing queued. In every idle cycle the monitor also compares the held flags with the last verdict, and at the end it confirms that the queue has drained, so a verdict that is early, late or missing is reported.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    localparam int unsigned ADDR_BYTES = 6;
    localparam int unsigned ADDR_W     = ADDR_BYTES * 8;

    typedef enum logic [1:0] {
        DST_UCAST = 2'd0,
        DST_MCAST = 2'd1,
        DST_BCAST = 2'd2
    } dst_kind_e;

    typedef struct packed {
        logic promisc;
        logic inv_da;
        logic pass_mcast;
        logic drop_bcast;
    } filt_cfg_t;

    typedef struct packed {
        logic pass;
        logic da_fail;
        logic sa_fail;
    } verdict_t;

    // Group bit: first bit on the wire, LSB of byte 0.
    function automatic logic group_bit(input logic [ADDR_W-1:0] a);
        return a[0];
    endfunction

endpackage

// File: rtl/rxaf_classify.sv
module rxaf_classify
    import rxaf_pkg::*;
#(
    parameter int unsigned NBYTES = ADDR_BYTES
) (
    input  logic [NBYTES*8-1:0] dst,
    input  logic [NBYTES*8-1:0] station,
    output dst_kind_e           kind,
    output logic                st_hit
);
    localparam int unsigned W = NBYTES * 8;

    logic [NBYTES-1:0] byte_eq;
    logic [NBYTES-1:0] byte_ones;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign byte_eq[b]   = (dst[b*8 +: 8] == station[b*8 +: 8]);
        assign byte_ones[b] = &dst[b*8 +: 8];
    end

    assign st_hit = &byte_eq;

    always_comb begin
        if (&byte_ones)
            kind = DST_BCAST;
        else if (dst[0])
            kind = DST_MCAST;
        else
            kind = DST_UCAST;
    end

    // Keep the unused width localparam meaningful for lint
    initial begin
        if (W != NBYTES * 8) $display("rxaf_classify: width mismatch");
    end

    // R6: a multicast class never carries a clear group bit
    always_comb begin
        if (kind == DST_MCAST)
            a_mcast_group_r6: assert (dst[0] == 1'b1);
    end
endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
    import rxaf_pkg::*;
(
    input  filt_cfg_t cfg,
    input  dst_kind_e kind,
    input  logic      st_hit,
    input  logic      hash_hit,
    input  logic      src_group,
    output verdict_t  verdict
);
    logic da_ok;

    always_comb begin
        unique case (kind)
            DST_BCAST: da_ok = !cfg.drop_bcast;
            DST_MCAST: da_ok = cfg.pass_mcast ? 1'b1 : (hash_hit ^ cfg.inv_da);
            default:   da_ok = st_hit ^ cfg.inv_da;
        endcase
    end

    always_comb begin
        if (cfg.promisc) begin
            verdict.pass    = 1'b1;
            verdict.da_fail = 1'b0;
            verdict.sa_fail = 1'b0;
        end else begin
            verdict.pass    = da_ok;
            verdict.da_fail = !da_ok;
            verdict.sa_fail = src_group;
        end
    end

    // R8: broadcast drop wins over pass-all-multicast
    always_comb begin
        if (!cfg.promisc && kind == DST_BCAST && cfg.drop_bcast)
            a_bcast_drop_r8: assert (!verdict.pass);
    end
endmodule

// File: rtl/rxaf_out_reg.sv
module rxaf_out_reg
    import rxaf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  verdict_t next_v,
    output logic     vld_q,
    output verdict_t v_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            v_q   <= '0;
        end else begin
            vld_q <= load;
            if (load) v_q <= next_v;
        end
    end

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(v_q));
    p_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        load |=> vld_q);
endmodule

// File: rtl/rxaf_top.sv
module rxaf_top
    import rxaf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_promisc,
    input  logic              cfg_inv_da,
    input  logic              cfg_pass_mcast,
    input  logic              cfg_drop_bcast,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic              hash_hit,
    output logic              res_valid,
    output logic              res_pass,
    output logic              res_da_fail,
    output logic              res_sa_fail
);
    filt_cfg_t cfg;
    dst_kind_e kind;
    logic      st_hit;
    verdict_t  next_v;
    verdict_t  cur_v;

    assign cfg = '{promisc:    cfg_promisc,
                   inv_da:     cfg_inv_da,
                   pass_mcast: cfg_pass_mcast,
                   drop_bcast: cfg_drop_bcast};

    rxaf_classify #(.NBYTES(ADDR_BYTES)) u_cls (
        .dst     (dst_addr),
        .station (station_addr),
        .kind    (kind),
        .st_hit  (st_hit)
    );

    rxaf_decide u_dec (
        .cfg       (cfg),
        .kind      (kind),
        .st_hit    (st_hit),
        .hash_hit  (hash_hit),
        .src_group (group_bit(src_addr)),
        .verdict   (next_v)
    );

    rxaf_out_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .load   (in_valid),
        .next_v (next_v),
        .vld_q  (res_valid),
        .v_q    (cur_v)
    );

    assign res_pass    = cur_v.pass;
    assign res_da_fail = cur_v.da_fail;
    assign res_sa_fail = cur_v.sa_fail;

    p_reset_quiet_r2: assert property (@(posedge clk)
        rst |=> !res_valid && !res_pass && !res_da_fail && !res_sa_fail);
    p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid);
    p_promisc_pass_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid && cfg_promisc |=> res_pass);
    p_promisc_clear_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid && cfg_promisc |=> !res_da_fail && !res_sa_fail);
    p_mcast_all_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid && !cfg_promisc && dst_addr[0] && !(&dst_addr) && cfg_pass_mcast
        |=> res_pass);
    p_sa_status_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid && !cfg_promisc |=> res_sa_fail == $past(src_addr[0]));
endmodule

// File: tb/tb_rxaf_top.sv
module tb_rxaf_top;
    import rxaf_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_promisc = 0, cfg_inv_da = 0, cfg_pass_mcast = 0, cfg_drop_bcast = 0;
    logic [47:0] station_addr = 48'h0;
    logic in_valid = 0;
    logic [47:0] dst_addr = 48'h0, src_addr = 48'h0;
    logic hash_hit = 0;
    logic res_valid, res_pass, res_da_fail, res_sa_fail;

    always #10 clk = ~clk;

    rxaf_top dut (.*);

    typedef struct {
        logic pass;
        logic daf;
        logic saf;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic last_pass = 0, last_daf = 0, last_saf = 0;
    logic mon_on = 0;
    bit   done = 0;

    localparam logic [47:0] STA  = 48'h5544_3322_1100;
    localparam logic [47:0] BCST = 48'hFFFF_FFFF_FFFF;

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic p, input logic inv, input logic am,
                                   input logic db, input logic [47:0] d,
                                   input logic [47:0] s, input logic h, input string tag);
        exp_t e;
        logic ok;
        e.tag = tag;
        if (d == BCST) ok = !db;                      // R8
        else if (d[0]) ok = am ? 1'b1 : (inv ? !h : h); // R6 R7 R9
        else ok = inv ? (d != station_addr) : (d == station_addr); // R5 R9
        if (p) begin e.pass = 1; e.daf = 0; e.saf = 0; end // R3 R4
        else begin e.pass = ok; e.daf = !ok; e.saf = s[0]; end // R10
        return e;
    endfunction

    task automatic send(input logic p, input logic inv, input logic am, input logic db,
                        input logic [47:0] d, input logic [47:0] s, input logic h,
                        input string tag);
        @(negedge clk);
        cfg_promisc = p; cfg_inv_da = inv; cfg_pass_mcast = am; cfg_drop_bcast = db;
        dst_addr = d; src_addr = s; hash_hit = h; in_valid = 1;
        q.push_back(model(p, inv, am, db, d, s, h, tag));
        @(negedge clk);
        in_valid = 0;
    endtask

    // Monitor: sample 5 ns after each rising edge
    always @(posedge clk) begin
        #5;
        if (mon_on && !done) begin
            if (res_valid) begin
                if (q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R1 unexpected strobe actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.tag, res_pass, e.pass, "pass");
                    chk(e.tag, res_da_fail, e.daf, "da_fail");
                    chk(e.tag, res_sa_fail, e.saf, "sa_fail");
                    last_pass = e.pass; last_daf = e.daf; last_saf = e.saf;
                end
            end else begin
                chk("R11", res_pass, last_pass, "held pass");
                chk("R11", res_da_fail, last_daf, "held da_fail");
                chk("R11", res_sa_fail, last_saf, "held sa_fail");
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        station_addr = STA;
        repeat (3) @(negedge clk);
        // R2: outputs quiet during reset
        chk("R2", res_valid, 1'b0, "valid in reset");
        chk("R2", res_pass, 1'b0, "pass in reset");
        chk("R2", res_da_fail | res_sa_fail, 1'b0, "fail flags in reset");
        rst = 0;
        @(negedge clk);
        chk("R2", res_valid, 1'b0, "valid after reset");
        mon_on = 1;

        // R5 unicast normal
        send(0,0,0,0, STA, 48'h0000_0000_0A02, 0, "R5 match");
        send(0,0,0,0, STA ^ 48'h0100_0000_0000, 48'h0, 0, "R5 miss");
        // R10 source group bit, pass unaffected
        send(0,0,0,0, STA, 48'h0000_0000_0001, 0, "R10 sa group");
        // R6 / R7 multicast
        send(0,0,1,0, 48'h0000_5E00_0001, 48'h0, 0, "R6 pass all");
        send(0,1,1,0, 48'h0000_5E00_0001, 48'h0, 1, "R6 inv ignored");
        send(0,0,0,0, 48'h0000_5E00_0001, 48'h0, 1, "R7 hash hit");
        send(0,0,0,0, 48'h0000_5E00_0001, 48'h0, 0, "R7 hash miss");
        // R9 inverse
        send(0,1,0,0, STA, 48'h0, 0, "R9 ucast match inv");
        send(0,1,0,0, 48'h0000_0000_0002, 48'h0, 0, "R9 ucast miss inv");
        send(0,1,0,0, 48'h0000_5E00_0001, 48'h0, 1, "R9 mcast hit inv");
        send(0,1,0,0, 48'h0000_5E00_0001, 48'h0, 0, "R9 mcast miss inv");
        // R8 broadcast
        send(0,0,0,0, BCST, 48'h0, 0, "R8 bcast pass");
        send(0,0,1,1, BCST, 48'h0, 1, "R8 drop over mcast");
        send(0,1,0,1, BCST, 48'h0, 0, "R8 drop with inv");
        send(0,1,0,0, BCST, 48'h0, 0, "R8 pass with inv");
        // R3 / R4 promiscuous
        send(1,0,0,1, BCST, 48'h0000_0000_0001, 0, "R3 promisc bcast");
        send(1,0,0,0, 48'h0000_0000_0004, 48'h0000_0000_0001, 0, "R4 promisc ucast");
        send(1,1,0,0, 48'h0000_5E00_0001, 48'h1, 0, "R4 promisc mcast");
        // R1 back-to-back strobes
        @(negedge clk);
        cfg_promisc = 0; cfg_inv_da = 0; cfg_pass_mcast = 0; cfg_drop_bcast = 0;
        in_valid = 1; dst_addr = STA; src_addr = 48'h0; hash_hit = 0;
        q.push_back(model(0,0,0,0, STA, 48'h0, 0, "R1 b2b first"));
        @(negedge clk);
        dst_addr = 48'h0000_0000_0006;
        q.push_back(model(0,0,0,0, 48'h0000_0000_0006, 48'h0, 0, "R1 b2b second"));
        @(negedge clk);
        in_valid = 0;
        // R11 idle hold with inputs changing
        dst_addr = STA; cfg_promisc = 1;
        repeat (5) @(negedge clk);
        done = 1;
        chk("R1", q.size() == 0, 1'b1, "queue drained");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule